// File: doc/BRIEF.md
# Knock-Unlocked Host Register Block with Stepping Memory Windows

This block sits between a host processor's register bus and a byte-wide local memory on an add-on coprocessor board. After reset it stays hidden. Every host write is dropped, and every host read returns the all-ones byte that an empty register slot gives on the stock machine. The board is also kept off the data bus. The block becomes visible only after the host writes a two-byte key to the control register. The first key byte is `$42`, and it must be followed directly by `$52`.

Once unlocked, the block offers two memory windows that work on their own. Each window has a 16-bit pointer that the host can write and read back one byte at a time. Each window also has a data register and a signed 8-bit stride. A byte moved through the data register goes to or from local memory at the pointer. The stride, sign-extended, is then added to the pointer modulo 65536.

Reads through the data registers are gated by a read-enable bit in the control register. This keeps a stray read cycle, such as the one a read-modify-write instruction makes, from moving a pointer. The host bus uses single-cycle strobes: register reads are combinational and register writes take effect at the clock edge. The memory port uses the same timing, with a combinational read, so the bus has no back-pressure.

Top module: `hrb_top`

## Requirements
- R1: While locked, host writes to any offset change no state and assert neither `mem_we` nor `mem_rd`; pointer bytes read 0 after unlocking if they were written only while locked.
- R2: While locked, a read at any offset returns `8'hFF` with `host_claim` low.
- R3: Writing `8'h42` and then `8'h52` to the control register (offset `6'h31`) unlocks the block. It then stays unlocked until reset, whatever is written to the control register. When unlocked, the control register reads `{7'b0, rd_en}`, which is never `8'hFF`.
- R4: An unlock attempt returns to its start if the write after `8'h42` is any other control value (including a second `8'h42`), or if it is a write to another offset.
- R5: Window 0 uses offsets `6'h32` (pointer low), `6'h33` (pointer high), `6'h34` (data) and `6'h35` (stride). Window 1 uses `6'h36` to `6'h39` in the same order. Pointer and stride bytes read back what was written or computed.
- R6: A write to a data offset drives `mem_we` with `mem_addr` equal to the window's pointer and `mem_wdata` equal to the written byte. The pointer then advances by the sign-extended stride. Strides run from -128 to 127.
- R7: Pointer updates wrap modulo 65536 in both directions.
- R8: The read-enable bit is control bit 0 and resets to 0. While it is 0, a data-offset read returns `8'h00`, does not assert `mem_rd`, and leaves the pointer unchanged.
- R9: While read-enable is 1, a data-offset read asserts `mem_rd`, returns `mem_rdata` taken at the pointer value from before the step, and then steps the pointer.
- R10: The two windows' pointers and strides are independent: an access through one never changes the other.
- R11: While unlocked, every host read asserts `host_claim`. Unmapped offsets read `8'h00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 6 | Register offset within the block's window |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_rdata | output | 8 | Read byte, valid in the strobe cycle |
| host_claim | output | 1 | Block drives the read data bus this cycle |
| mem_addr | output | 16 | Local memory byte address |
| mem_wdata | output | 8 | Local memory write byte |
| mem_we | output | 1 | Local memory write enable |
| mem_rd | output | 1 | Local memory read enable |
| mem_rdata | input | 8 | Local memory read byte, combinational from mem_addr |

## Verification
The hardest states to reach from the ports are the knock that is broken halfway and the pointer that crosses the 64 KiB boundary with a negative stride. A locked block shows nothing but `$FF`, so the only evidence of a broken knock is that a later, correct key still does not open the block. The stimulus table therefore interleaves broken key sequences (a foreign register write, a doubled `$42`) with reads of the control register. It then parks window 0 just below `$FFFF` and walks it forward across zero. Next it sets a stride of -3 so that the pointer borrows back over zero. After that it turns on read-enable, so that the values returned through the data register show both the address used before the step and the address after it.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam int          DW        = 8;
  localparam int          PTR_W     = 16;
  localparam int          RA_W      = 6;
  localparam int          SUB_W     = 2;
  localparam logic [5:0]  CTRL_OFS  = 6'h31;
  localparam logic [5:0]  WIN_BASE  = 6'h32;
  localparam logic [7:0]  KEY_FIRST = 8'h42;
  localparam logic [7:0]  KEY_LAST  = 8'h52;
  localparam int          RDEN_BIT  = 0;
  localparam logic [1:0]  SUB_LO    = 2'd0;
  localparam logic [1:0]  SUB_HI    = 2'd1;
  localparam logic [1:0]  SUB_DATA  = 2'd2;
  localparam logic [1:0]  SUB_STEP  = 2'd3;

  typedef enum logic [1:0] {
    KN_IDLE = 2'd0,
    KN_HALF = 2'd1,
    KN_OPEN = 2'd2
  } knock_t;
endpackage

// File: rtl/hrb_knock.sv
module hrb_knock
  import hrb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic         other_wr,
  input  logic [W-1:0] wdata,
  output logic         unlocked
);
  knock_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KN_IDLE;
    end else begin
      case (st_q)
        KN_IDLE: if (ctrl_wr && wdata == W'(KEY_FIRST)) st_q <= KN_HALF;
        KN_HALF: begin
          if (ctrl_wr)       st_q <= (wdata == W'(KEY_LAST)) ? KN_OPEN : KN_IDLE;
          else if (other_wr) st_q <= KN_IDLE;
        end
        KN_OPEN: st_q <= KN_OPEN;
        default: st_q <= KN_IDLE;
      endcase
    end
  end

  assign unlocked = (st_q == KN_OPEN);

  // R3: once open, stays open until reset
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R4: opening only on the last key byte after a half-state
  p_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(ctrl_wr && st_q == KN_HALF)) |=> !unlocked);
endmodule

// File: rtl/hrb_decode.sv
module hrb_decode
  import hrb_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic [RA_W-1:0]  addr,
  output logic             is_ctrl,
  output logic [NWIN-1:0]  win_hit,
  output logic [SUB_W-1:0] sub
);
  localparam int IDX_W = RA_W - SUB_W;

  logic [RA_W-1:0]  off;
  logic [IDX_W-1:0] idx;
  logic             above;

  assign is_ctrl = (addr == CTRL_OFS);
  assign above   = (addr >= WIN_BASE);
  assign off     = addr - WIN_BASE;
  assign idx     = off[RA_W-1:SUB_W];
  assign sub     = off[SUB_W-1:0];

  for (genvar i = 0; i < NWIN; i++) begin : g_hit
    assign win_hit[i] = above && (idx == IDX_W'(i));
  end

  // R10: a single offset never selects two windows
  always_comb begin
    a_onehit_r10: assert ($onehot0(win_hit));
  end
endmodule

// File: rtl/hrb_port.sv
module hrb_port #(
  parameter int PTR_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_step,
  input  logic             xfer,
  input  logic [DW-1:0]    wdata,
  output logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    step
);
  localparam int HI_W = PTR_W - DW;

  logic [PTR_W-1:0] step_ext;

  assign step_ext = {{HI_W{step[DW-1]}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      step <= '0;
    end else begin
      if (wr_step) step <= wdata;
      if (xfer)        ptr <= ptr + step_ext;
      else if (wr_lo)  ptr[DW-1:0] <= wdata;
      else if (wr_hi)  ptr[PTR_W-1:DW] <= wdata[HI_W-1:0];
    end
  end

  // R6: pointer moves only on a transfer or a host pointer write
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer || wr_lo || wr_hi) |=> $stable(ptr));

  // R5: stride changes only when written
  p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_step |=> $stable(step));
endmodule

// File: rtl/hrb_top.sv
module hrb_top
  import hrb_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RA_W-1:0]  host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_wr,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  output logic             host_claim,
  output logic [PTR_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic             mem_rd,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int HI_W = PTR_W - DW;

  logic             unlocked;
  logic             is_ctrl;
  logic [NWIN-1:0]  win_hit;
  logic [SUB_W-1:0] sub;
  logic             rd_en_q;
  logic             wr_acc, rd_acc, data_hit;
  logic [NWIN-1:0]  w_lo, w_hi, w_step, w_xfer;
  logic [PTR_W-1:0] ptr_a  [NWIN];
  logic [DW-1:0]    step_a [NWIN];
  logic [PTR_W-1:0] sel_ptr;
  logic [DW-1:0]    sel_step;

  hrb_knock #(.W(DW)) u_knock (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (host_wr && is_ctrl),
    .other_wr (host_wr && !is_ctrl),
    .wdata    (host_wdata),
    .unlocked (unlocked)
  );

  hrb_decode #(.NWIN(NWIN)) u_dec (
    .addr    (host_addr),
    .is_ctrl (is_ctrl),
    .win_hit (win_hit),
    .sub     (sub)
  );

  assign wr_acc   = host_wr && unlocked;
  assign rd_acc   = host_rd && !host_wr && unlocked;
  assign data_hit = (|win_hit) && (sub == SUB_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_en_q <= 1'b0;
    else if (wr_acc && is_ctrl) rd_en_q <= host_wdata[RDEN_BIT];
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign w_lo[i]   = wr_acc && win_hit[i] && (sub == SUB_LO);
    assign w_hi[i]   = wr_acc && win_hit[i] && (sub == SUB_HI);
    assign w_step[i] = wr_acc && win_hit[i] && (sub == SUB_STEP);
    assign w_xfer[i] = win_hit[i] && (sub == SUB_DATA) &&
                       (wr_acc || (rd_acc && rd_en_q));

    hrb_port #(.PTR_W(PTR_W), .DW(DW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (w_lo[i]),
      .wr_hi   (w_hi[i]),
      .wr_step (w_step[i]),
      .xfer    (w_xfer[i]),
      .wdata   (host_wdata),
      .ptr     (ptr_a[i]),
      .step    (step_a[i])
    );
  end

  always_comb begin
    sel_ptr  = '0;
    sel_step = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_hit[i]) begin
        sel_ptr  = ptr_a[i];
        sel_step = step_a[i];
      end
    end
  end

  assign mem_addr   = sel_ptr;
  assign mem_wdata  = host_wdata;
  assign mem_we     = wr_acc && data_hit;
  assign mem_rd     = rd_acc && rd_en_q && data_hit;
  assign host_claim = host_rd && unlocked;

  always_comb begin
    host_rdata = '0;
    if (!unlocked) begin
      host_rdata = '1;
    end else if (is_ctrl) begin
      host_rdata = '0;
      host_rdata[RDEN_BIT] = rd_en_q;
    end else if (|win_hit) begin
      case (sub)
        SUB_LO:   host_rdata = sel_ptr[DW-1:0];
        SUB_HI:   host_rdata = DW'(sel_ptr[PTR_W-1:PTR_W-HI_W]);
        SUB_DATA: host_rdata = mem_rd ? mem_rdata : '0;
        default:  host_rdata = sel_step;
      endcase
    end
  end

  // R1: no memory traffic while hidden
  p_lock_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!mem_we && !mem_rd));

  // R2: hidden block never takes the data bus
  p_lock_noclaim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !host_claim);

  // R8: memory reads only with read-enable set
  p_rd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> rd_en_q);

  // R9: never read and write memory together
  p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_rd));

  // R11: every unlocked read is claimed
  p_claim_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && unlocked) |-> host_claim);
endmodule

// File: tb/tb_hrb_top.sv
module tb_hrb_top;
  localparam int CLK_PER = 10;
  localparam logic [1:0] OP_W  = 2'd0;  // write, expect no memory write
  localparam logic [1:0] OP_WM = 2'd1;  // write, expect memory write at exp
  localparam logic [1:0] OP_R  = 2'd2;  // read: exp = {mrd, claim, byte}
  localparam int NV = 49;

  // {op, addr, data, exp}
  localparam logic [31:0] VEC [NV] = '{
    {OP_R,  6'h31, 8'h00, 16'h00FF},  // 0  R2 locked ctrl reads FF
    {OP_W,  6'h32, 8'h10, 16'h0000},  // 1  R1 locked write dropped
    {OP_W,  6'h34, 8'h77, 16'h0000},  // 2  R1 no mem write
    {OP_W,  6'h31, 8'h42, 16'h0000},  // 3
    {OP_W,  6'h32, 8'h00, 16'h0000},  // 4  R4 foreign write breaks knock
    {OP_W,  6'h31, 8'h52, 16'h0000},  // 5
    {OP_R,  6'h31, 8'h00, 16'h00FF},  // 6  R4 still locked
    {OP_W,  6'h31, 8'h42, 16'h0000},  // 7
    {OP_W,  6'h31, 8'h42, 16'h0000},  // 8  R4 doubled first key
    {OP_W,  6'h31, 8'h52, 16'h0000},  // 9
    {OP_R,  6'h31, 8'h00, 16'h00FF},  // 10 R4 still locked
    {OP_W,  6'h31, 8'h42, 16'h0000},  // 11 R3
    {OP_W,  6'h31, 8'h52, 16'h0000},  // 12 R3
    {OP_R,  6'h31, 8'h00, 16'h0100},  // 13 R3 open, rd_en 0
    {OP_R,  6'h32, 8'h00, 16'h0100},  // 14 R1 locked pointer write lost
    {OP_W,  6'h32, 8'hFE, 16'h0000},  // 15 R5
    {OP_W,  6'h33, 8'hFF, 16'h0000},  // 16 R5
    {OP_W,  6'h35, 8'h01, 16'h0000},  // 17 R5
    {OP_WM, 6'h34, 8'hAA, 16'hFFFE},  // 18 R6
    {OP_WM, 6'h34, 8'hBB, 16'hFFFF},  // 19 R6
    {OP_WM, 6'h34, 8'hCC, 16'h0000},  // 20 R7 forward wrap
    {OP_R,  6'h32, 8'h00, 16'h0101},  // 21 R5
    {OP_R,  6'h33, 8'h00, 16'h0100},  // 22 R5
    {OP_W,  6'h36, 8'h10, 16'h0000},  // 23 R10
    {OP_W,  6'h37, 8'h20, 16'h0000},  // 24 R10
    {OP_W,  6'h39, 8'hFE, 16'h0000},  // 25 R10 stride -2
    {OP_WM, 6'h38, 8'h11, 16'h2010},  // 26 R10
    {OP_R,  6'h36, 8'h00, 16'h010E},  // 27 R6 negative stride
    {OP_R,  6'h32, 8'h00, 16'h0101},  // 28 R10 window 0 untouched
    {OP_W,  6'h39, 8'h80, 16'h0000},  // 29 R6 stride -128
    {OP_WM, 6'h38, 8'h22, 16'h200E},  // 30 R6
    {OP_R,  6'h37, 8'h00, 16'h011F},  // 31 R6
    {OP_R,  6'h36, 8'h00, 16'h018E},  // 32 R6
    {OP_W,  6'h35, 8'hFD, 16'h0000},  // 33 R7 stride -3
    {OP_WM, 6'h34, 8'h33, 16'h0001},  // 34 R7
    {OP_R,  6'h33, 8'h00, 16'h01FF},  // 35 R7 backward wrap
    {OP_R,  6'h32, 8'h00, 16'h01FE},  // 36 R7
    {OP_R,  6'h34, 8'h00, 16'h0100},  // 37 R8 gated read
    {OP_R,  6'h32, 8'h00, 16'h01FE},  // 38 R8 pointer unchanged
    {OP_W,  6'h31, 8'h01, 16'h0000},  // 39 R8 enable reads
    {OP_R,  6'h31, 8'h00, 16'h0101},  // 40 R3 ctrl shows bit
    {OP_R,  6'h34, 8'h00, 16'h035B},  // 41 R9 byte at FFFE
    {OP_R,  6'h34, 8'h00, 16'h035E},  // 42 R9 byte at FFFB
    {OP_R,  6'h32, 8'h00, 16'h01F8},  // 43 R9 pointer stepped
    {OP_R,  6'h35, 8'h00, 16'h01FD},  // 44 R5 stride readback
    {OP_W,  6'h31, 8'h42, 16'h0000},  // 45 R3
    {OP_R,  6'h31, 8'h00, 16'h0100},  // 46 R3 stays open
    {OP_R,  6'h34, 8'h00, 16'h0100},  // 47 R8 gated again
    {OP_R,  6'h3F, 8'h00, 16'h0100}   // 48 R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        host_claim;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_rd;
  logic [7:0]  mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

  hrb_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .host_claim (host_claim),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rd     (mem_rd),
    .mem_rdata  (mem_rdata)
  );

  task automatic apply(input logic [1:0] op, input logic [5:0] a,
                       input logic [7:0] d, input logic [15:0] e, input int tag);
    logic [15:0] act;
    logic [15:0] exp;
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = (op != OP_R);
    host_rd    = (op == OP_R);
    #(CLK_PER/4);
    n_chk++;
    case (op)
      OP_W:    begin act = {15'b0, mem_we}; exp = 16'h0000; end
      OP_WM:   begin act = mem_we ? mem_addr : 16'hDEAD;
                     exp = (mem_wdata == d) ? e : 16'hBEEF; end
      default: begin act = {6'b0, mem_rd, host_claim, host_rdata}; exp = e; end
    endcase
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d vec off %h: actual %h expected %h", tag, a, act, exp);
    end
  endtask

  function automatic int tag_of(input int k);
    if (k <= 2)  return 1;
    if (k <= 10) return 4;
    if (k <= 14) return 3;
    if (k <= 22) return 6;
    if (k <= 28) return 10;
    if (k <= 36) return 7;
    if (k <= 40) return 8;
    if (k <= 44) return 9;
    return 11;
  endfunction

  initial begin
    #(CLK_PER * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][31:30], VEC[k][29:24], VEC[k][23:16], VEC[k][15:0], tag_of(k));
    end

    // Directed: mid-run reset hides the block again (R2) and clears pointers (R5)
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(OP_R, 6'h31, 8'h00, 16'h00FF, 2);   // R2 ctrl after reset
    apply(OP_R, 6'h32, 8'h00, 16'h00FF, 2);   // R2 pointer slot hidden
    apply(OP_W, 6'h31, 8'h42, 16'h0000, 3);
    apply(OP_W, 6'h31, 8'h52, 16'h0000, 3);
    apply(OP_R, 6'h32, 8'h00, 16'h0100, 5);   // R5 pointer reset to zero
    apply(OP_R, 6'h39, 8'h00, 16'h0100, 5);   // R5 stride reset to zero
    apply(OP_WM, 6'h38, 8'h5C, 16'h0000, 6);  // R6 zero stride holds pointer
    apply(OP_WM, 6'h38, 8'h5D, 16'h0000, 6);  // R6

    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule